// File: doc/BRIEF.md
# Dual-Path Register Renamer with Store Cancellation

This block renames instructions on both sides of one unresolved branch at the same time, so that the front end can fetch down the taken and the not-taken direction together. Each incoming instruction carries a path bit. A 3-bit logical register name is widened into a 5-bit physical register index through one of two rename tables, one per path. Destination registers are drawn from a shared free list, so a logical register written on both sides lands in two distinct physical registers. Wrong-path instructions may still write their own physical registers, because nothing on the correct path ever reads those registers.

Every physical register and every pending store carries a two-bit dependency mask. A bit is set when the value was produced on that path during speculation, and the mask is inherited from the source operands. When the branch resolves, fetch narrows to the winning path and the winning table is copied over the losing one. The registers the losing path allocated go back to the free list. Every pending store whose mask names the losing path is marked cancelled. Stores presented for write-back are then reported as commit, squash (turn into a bubble) or hold (still speculative).

Top module: `dr_rename`

## Requirements
- R1: After reset, speculation is off, `fetch_en` is 2'b01, logical register i maps to physical register i on both paths, and the first destination allocated is physical register 8.
- R2: An accepted instruction reads its sources from its own path's table (from the live path's table outside speculation), reports the previous mapping of its destination on `out_old`, and receives the lowest-numbered free physical register on `out_pd`.
- R3: While speculating, a logical register written on path 0 and on path 1 maps to two different physical registers, and each path's table sees only its own writes.
- R4: With no free physical register, an instruction with a destination is refused (`in_ready` low, `in_accept` low) on either path; with no free store slot, a store is refused; a refused instruction changes nothing.
- R5: In the cycle a resolution is taken, `in_ready` is low. From the next cycle on, `fetch_en` is the one-hot of the winner (bit 0 for path 0, bit 1 for path 1), and an instruction tagged with the losing path is not accepted and allocates nothing.
- R6: A store is reported on exactly one of commit, squash or hold. A store renamed on the losing path is squashed. A store on the winning path, or a store renamed before the branch was forked, is committed. A store whose mask still names an unresolved path is held.
- R7: The dependency mask of a result or a store is the OR of its sources' masks plus its own path bit when speculating. A store that depends directly or through a chain of registers on a losing-path result is squashed.
- R8: At resolution, the registers allocated by the losing path return to the free list, and both tables take the winner's mappings.
- R9: A release (`rel_valid` with `rel_preg`) returns that physical register to the free list from the next cycle.
- R10: Outside speculation, a rename writes both tables, so after a fork both paths see every earlier mapping.
- R11: A fork while already speculating is ignored. A resolution while not speculating is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fork_valid | input | 1 | Start speculation across one branch |
| res_valid | input | 1 | Branch outcome is known |
| res_win | input | 1 | Winning path of the branch |
| in_valid | input | 1 | Instruction presented for renaming |
| in_path | input | 1 | Path tag of the instruction |
| in_src_a | input | 3 | First logical source |
| in_src_b | input | 3 | Second logical source |
| in_has_dst | input | 1 | Instruction writes a destination |
| in_dst | input | 3 | Logical destination |
| in_is_store | input | 1 | Instruction is a store |
| in_ready | output | 1 | Resources available for this instruction |
| in_accept | output | 1 | Instruction renamed this cycle |
| out_pa | output | 5 | Physical register of source a |
| out_pb | output | 5 | Physical register of source b |
| out_pd | output | 5 | Newly allocated destination register |
| out_old | output | 5 | Previous mapping of the destination |
| out_sid | output | 3 | Store slot given to an accepted store |
| rel_valid | input | 1 | Return a physical register to the free list |
| rel_preg | input | 5 | Register being returned |
| wb_valid | input | 1 | A store reaches write-back |
| wb_sid | input | 3 | Store slot at write-back |
| wb_commit | output | 1 | Store may write memory |
| wb_squash | output | 1 | Store becomes a bubble |
| wb_hold | output | 1 | Store is still speculative |
| fetch_en | output | 2 | Per-path fetch enable |
| spec_active | output | 1 | Speculation in progress |

## Verification
Rename results (`in_ready`, `in_accept`, the register indices and the store slot) and the write-back verdicts are combinational in the same cycle as their inputs. Every effect on state appears from the next cycle: table contents, free list, dependency masks, `fetch_en` and `spec_active`. The bench drives inputs at the falling edge and compares all outputs against a behavioural model 2 ns later, before the rising edge. It then moves the model's state forward just after the rising edge, so a change due one cycle later is compared in the next step.

// File: rtl/dr_pkg.sv
`timescale 1ns/1ps
package dr_pkg;
  localparam int LREGS  = 8;
  localparam int PREGS  = 32;
  localparam int STORES = 8;
  localparam int LW = $clog2(LREGS);
  localparam int PW = $clog2(PREGS);
  localparam int SW = $clog2(STORES);

  typedef logic [LW-1:0] lreg_t;
  typedef logic [PW-1:0] preg_t;
  typedef logic [SW-1:0] sid_t;
  typedef logic [1:0]    pmask_t;

  // one-hot mask naming a path
  function automatic pmask_t path_bit(input logic p);
    path_bit = p ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/dr_freelist.sv
`timescale 1ns/1ps
module dr_freelist import dr_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  alloc,
  input  logic  alloc_spec,
  input  logic  alloc_path,
  input  logic  resolve,
  input  logic  win,
  input  logic  rel_valid,
  input  preg_t rel_preg,
  output logic  free_any,
  output preg_t free_idx
);
  logic [PREGS-1:0] free_q, by0_q, by1_q;
  logic [PREGS-1:0] grab_vec, ret_vec, lost_vec;

  function automatic preg_t first_set(input logic [PREGS-1:0] v);
    first_set = '0;
    for (int i = PREGS - 1; i >= 0; i--)
      if (v[i]) first_set = preg_t'(i);
  endfunction

  assign free_any = |free_q;
  assign free_idx = first_set(free_q);
  assign grab_vec = alloc ? ({{(PREGS-1){1'b0}}, 1'b1} << free_idx) : '0;
  assign lost_vec = win ? by0_q : by1_q;
  assign ret_vec  = (rel_valid ? ({{(PREGS-1){1'b0}}, 1'b1} << rel_preg) : '0)
                  | (resolve ? lost_vec : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= {PREGS{1'b1}} << LREGS;
      by0_q  <= '0;
      by1_q  <= '0;
    end else begin
      free_q <= (free_q & ~grab_vec) | ret_vec;
      if (resolve) begin
        by0_q <= '0;
        by1_q <= '0;
      end else if (alloc && alloc_spec) begin
        if (alloc_path) by1_q <= by1_q | grab_vec;
        else            by0_q <= by0_q | grab_vec;
      end
    end
  end

  assert_grab_from_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> free_any);
  assert_paths_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (by0_q & by1_q) == '0);
  assert_loser_returned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(resolve) |-> ((free_q & $past(lost_vec)) == $past(lost_vec)));
endmodule

// File: rtl/dr_maptable.sv
`timescale 1ns/1ps
module dr_maptable import dr_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_path,
  input  lreg_t rd_a,
  input  lreg_t rd_b,
  input  lreg_t rd_d,
  output preg_t map_a,
  output preg_t map_b,
  output preg_t map_d,
  input  logic  wr_en,
  input  logic  wr_spec,
  input  logic  wr_path,
  input  lreg_t wr_lreg,
  input  preg_t wr_preg,
  input  logic  resolve,
  input  logic  win,
  output logic  maps_same
);
  preg_t tbl [2][LREGS];

  function automatic logic tables_equal(input preg_t t [2][LREGS]);
    tables_equal = 1'b1;
    for (int l = 0; l < LREGS; l++)
      if (t[0][l] != t[1][l]) tables_equal = 1'b0;
  endfunction

  assign map_a     = tbl[rd_path][rd_a];
  assign map_b     = tbl[rd_path][rd_b];
  assign map_d     = tbl[rd_path][rd_d];
  assign maps_same = tables_equal(tbl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++)
        for (int l = 0; l < LREGS; l++)
          tbl[p][l] <= preg_t'(l);
    end else if (resolve) begin
      for (int l = 0; l < LREGS; l++)
        tbl[!win][l] <= tbl[win][l];
    end else if (wr_en) begin
      for (int p = 0; p < 2; p++)
        if (!wr_spec || wr_path == 1'(p))
          tbl[p][wr_lreg] <= wr_preg;
    end
  end

  assert_winner_copied_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(resolve) |-> maps_same);
  assert_spec_write_one_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_spec && !resolve && maps_same && (map_d != wr_preg) && (rd_d == wr_lreg))
      |=> !maps_same);
endmodule

// File: rtl/dr_storegate.sv
`timescale 1ns/1ps
module dr_storegate import dr_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  spec,
  input  logic  path,
  input  preg_t src_a,
  input  preg_t src_b,
  input  logic  dst_wr,
  input  preg_t dst_preg,
  input  logic  st_alloc,
  input  logic  resolve,
  input  logic  win,
  input  logic  wb_valid,
  input  sid_t  wb_sid,
  output logic  slot_any,
  output sid_t  slot_idx,
  output logic  wb_commit,
  output logic  wb_squash,
  output logic  wb_hold
);
  pmask_t           dep_q  [PREGS];
  pmask_t           sdep_q [STORES];
  logic [STORES-1:0] used_q, cancel_q;
  pmask_t           new_mask;
  logic             wb_hit, wb_spec, wb_done;

  function automatic sid_t first_clear(input logic [STORES-1:0] v);
    first_clear = '0;
    for (int i = STORES - 1; i >= 0; i--)
      if (!v[i]) first_clear = sid_t'(i);
  endfunction

  assign new_mask  = dep_q[src_a] | dep_q[src_b] | (spec ? path_bit(path) : 2'b00);
  assign slot_any  = ~&used_q;
  assign slot_idx  = first_clear(used_q);
  assign wb_hit    = wb_valid && used_q[wb_sid];
  assign wb_spec   = |sdep_q[wb_sid];
  assign wb_hold   = wb_hit && wb_spec;
  assign wb_commit = wb_hit && !wb_spec && !cancel_q[wb_sid];
  assign wb_squash = wb_hit && !wb_spec && cancel_q[wb_sid];
  assign wb_done   = wb_commit || wb_squash;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PREGS; i++) dep_q[i] <= '0;
      for (int s = 0; s < STORES; s++) sdep_q[s] <= '0;
      used_q   <= '0;
      cancel_q <= '0;
    end else begin
      if (resolve) begin
        for (int i = 0; i < PREGS; i++) dep_q[i] <= '0;
        for (int s = 0; s < STORES; s++) begin
          if (sdep_q[s][!win]) cancel_q[s] <= 1'b1;
          sdep_q[s] <= '0;
        end
      end else begin
        if (dst_wr) dep_q[dst_preg] <= new_mask;
        if (st_alloc) begin
          used_q[slot_idx]   <= 1'b1;
          sdep_q[slot_idx]   <= new_mask;
          cancel_q[slot_idx] <= 1'b0;
        end
      end
      if (wb_done) used_q[wb_sid] <= 1'b0;
    end
  end

  assert_slot_alloc_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_alloc |-> slot_any);
  assert_one_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_commit, wb_squash, wb_hold}));
  assert_loser_store_squashed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve && wb_hit && sdep_q[wb_sid][!win] && !wb_done) |=> !wb_commit || !(wb_valid && $stable(wb_sid)));
endmodule

// File: rtl/dr_rename.sv
`timescale 1ns/1ps
module dr_rename import dr_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fork_valid,
  input  logic          res_valid,
  input  logic          res_win,
  input  logic          in_valid,
  input  logic          in_path,
  input  logic [LW-1:0] in_src_a,
  input  logic [LW-1:0] in_src_b,
  input  logic          in_has_dst,
  input  logic [LW-1:0] in_dst,
  input  logic          in_is_store,
  output logic          in_ready,
  output logic          in_accept,
  output logic [PW-1:0] out_pa,
  output logic [PW-1:0] out_pb,
  output logic [PW-1:0] out_pd,
  output logic [PW-1:0] out_old,
  output logic [SW-1:0] out_sid,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_preg,
  input  logic          wb_valid,
  input  logic [SW-1:0] wb_sid,
  output logic          wb_commit,
  output logic          wb_squash,
  output logic          wb_hold,
  output logic [1:0]    fetch_en,
  output logic          spec_active
);
  logic  spec_q, live_q;
  logic  do_fork, do_resolve, path_ok, rd_path;
  logic  free_any, slot_any, alloc, st_alloc, maps_same;
  preg_t free_idx, map_a, map_b, map_d;
  sid_t  slot_idx;

  // named control events
  assign do_fork    = fork_valid && !spec_q;
  assign do_resolve = res_valid && spec_q;
  assign path_ok    = spec_q || (in_path == live_q);
  assign rd_path    = spec_q ? in_path : live_q;
  assign in_ready   = !do_resolve && (!in_has_dst || free_any) && (!in_is_store || slot_any);
  assign in_accept  = in_valid && in_ready && path_ok;
  assign alloc      = in_accept && in_has_dst;
  assign st_alloc   = in_accept && in_is_store;

  assign out_pa      = map_a;
  assign out_pb      = map_b;
  assign out_pd      = free_idx;
  assign out_old     = map_d;
  assign out_sid     = slot_idx;
  assign fetch_en    = spec_q ? 2'b11 : path_bit(live_q);
  assign spec_active = spec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spec_q <= 1'b0;
      live_q <= 1'b0;
    end else if (do_resolve) begin
      spec_q <= 1'b0;
      live_q <= res_win;
    end else if (do_fork) begin
      spec_q <= 1'b1;
    end
  end

  dr_freelist u_free (
    .clk(clk), .rst_n(rst_n),
    .alloc(alloc), .alloc_spec(spec_q), .alloc_path(in_path),
    .resolve(do_resolve), .win(res_win),
    .rel_valid(rel_valid), .rel_preg(rel_preg),
    .free_any(free_any), .free_idx(free_idx)
  );

  dr_maptable u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_path(rd_path), .rd_a(in_src_a), .rd_b(in_src_b), .rd_d(in_dst),
    .map_a(map_a), .map_b(map_b), .map_d(map_d),
    .wr_en(alloc), .wr_spec(spec_q), .wr_path(in_path),
    .wr_lreg(in_dst), .wr_preg(free_idx),
    .resolve(do_resolve), .win(res_win), .maps_same(maps_same)
  );

  dr_storegate u_store (
    .clk(clk), .rst_n(rst_n),
    .spec(spec_q), .path(in_path),
    .src_a(map_a), .src_b(map_b),
    .dst_wr(alloc), .dst_preg(free_idx),
    .st_alloc(st_alloc),
    .resolve(do_resolve), .win(res_win),
    .wb_valid(wb_valid), .wb_sid(wb_sid),
    .slot_any(slot_any), .slot_idx(slot_idx),
    .wb_commit(wb_commit), .wb_squash(wb_squash), .wb_hold(wb_hold)
  );

  assert_fetch_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(res_valid && spec_q) |-> (fetch_en == path_bit($past(res_win))));
  assert_stall_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_has_dst && !free_any) |-> !in_accept);
  assert_maps_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !spec_q |-> maps_same);
  assert_nested_fork_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_q && fork_valid && !res_valid) |=> spec_q);
endmodule

// File: tb/tb_dr_rename.sv
`timescale 1ns/1ps
module tb_dr_rename;
  import dr_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, fork_valid, res_valid, res_win, in_valid, in_path, in_has_dst, in_is_store;
  logic [LW-1:0] in_src_a, in_src_b, in_dst;
  logic in_ready, in_accept, rel_valid, wb_valid, wb_commit, wb_squash, wb_hold, spec_active;
  logic [PW-1:0] out_pa, out_pb, out_pd, out_old, rel_preg;
  logic [SW-1:0] out_sid, wb_sid;
  logic [1:0] fetch_en;

  dr_rename dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_map [2][LREGS];
  bit m_free [PREGS];
  bit m_ab [2][PREGS];
  int m_dep [PREGS];
  bit m_sv [STORES];
  int m_sdep [STORES];
  bit m_scan [STORES];
  bit m_spec;
  int m_live;

  function automatic int low_free();
    for (int i = 0; i < PREGS; i++) if (m_free[i]) return i;
    return -1;
  endfunction

  function automatic int low_slot();
    for (int s = 0; s < STORES; s++) if (!m_sv[s]) return s;
    return -1;
  endfunction

  function automatic bit releasable(int r);
    if (m_free[r] || m_ab[0][r] || m_ab[1][r]) return 0;
    for (int p = 0; p < 2; p++)
      for (int l = 0; l < LREGS; l++) if (m_map[p][l] == r) return 0;
    return 1;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_in();
    fork_valid = 0; res_valid = 0; res_win = 0; in_valid = 0; in_path = 0;
    in_src_a = 0; in_src_b = 0; in_has_dst = 0; in_dst = 0; in_is_store = 0;
    rel_valid = 0; rel_preg = 0; wb_valid = 0; wb_sid = 0;
  endtask

  // inputs already driven at the falling edge; compare, then advance the model
  task automatic step(string tag);
    int lf, ls, rp, nm, fe, lose;
    bit dres, dfork, pok, rdy, acc, went, hold, com, sq;
    #2;
    lf = low_free(); ls = low_slot();
    dres = res_valid && m_spec;
    dfork = fork_valid && !m_spec;
    pok = m_spec || (int'(in_path) == m_live);
    rp = m_spec ? int'(in_path) : m_live;
    rdy = !dres && (!in_has_dst || lf >= 0) && (!in_is_store || ls >= 0);
    acc = in_valid && rdy && pok;
    nm = m_dep[m_map[rp][in_src_a]] | m_dep[m_map[rp][in_src_b]] | (m_spec ? (1 << in_path) : 0);
    went = wb_valid && m_sv[wb_sid];
    hold = went && m_sdep[wb_sid] != 0;
    com = went && m_sdep[wb_sid] == 0 && !m_scan[wb_sid];
    sq = went && m_sdep[wb_sid] == 0 && m_scan[wb_sid];
    fe = m_spec ? 3 : (1 << m_live);
    chk(tag, "in_ready", in_ready, rdy);
    chk(tag, "in_accept", in_accept, acc);
    chk(tag, "fetch_en", fetch_en, fe);
    chk(tag, "spec_active", spec_active, m_spec);
    chk(tag, "wb_commit", wb_commit, com);
    chk(tag, "wb_squash", wb_squash, sq);
    chk(tag, "wb_hold", wb_hold, hold);
    if (acc) begin
      chk(tag, "out_pa", out_pa, m_map[rp][in_src_a]);
      chk(tag, "out_pb", out_pb, m_map[rp][in_src_b]);
      chk(tag, "out_old", out_old, m_map[rp][in_dst]);
      if (in_has_dst) chk(tag, "out_pd", out_pd, lf);
      if (in_is_store) chk(tag, "out_sid", out_sid, ls);
    end
    @(posedge clk);
    if (acc && in_has_dst) begin
      m_free[lf] = 0;
      m_dep[lf] = nm;
      if (m_spec) begin
        m_map[in_path][in_dst] = lf;
        m_ab[in_path][lf] = 1;
      end else begin
        m_map[0][in_dst] = lf;
        m_map[1][in_dst] = lf;
      end
    end
    if (acc && in_is_store) begin
      m_sv[ls] = 1; m_sdep[ls] = nm; m_scan[ls] = 0;
    end
    if (com || sq) m_sv[wb_sid] = 0;
    if (rel_valid) m_free[rel_preg] = 1;
    if (dres) begin
      lose = res_win ? 0 : 1;
      for (int l = 0; l < LREGS; l++) m_map[lose][l] = m_map[res_win][l];
      for (int i = 0; i < PREGS; i++) begin
        if (m_ab[lose][i]) m_free[i] = 1;
        m_ab[0][i] = 0; m_ab[1][i] = 0; m_dep[i] = 0;
      end
      for (int s = 0; s < STORES; s++) begin
        if ((m_sdep[s] >> lose) & 1) m_scan[s] = 1;
        m_sdep[s] = 0;
      end
      m_spec = 0; m_live = res_win;
    end
    if (dfork) m_spec = 1;
    @(negedge clk);
    clear_in();
  endtask

  task automatic ren(string tag, bit p, int a, int b, bit hd, int d, bit st);
    in_valid = 1; in_path = p; in_src_a = a[LW-1:0]; in_src_b = b[LW-1:0];
    in_has_dst = hd; in_dst = d[LW-1:0]; in_is_store = st;
    step(tag);
  endtask

  task automatic wb(string tag, int s);
    wb_valid = 1; wb_sid = s[SW-1:0];
    step(tag);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst_n = 0;
    for (int l = 0; l < LREGS; l++) begin m_map[0][l] = l; m_map[1][l] = l; end
    for (int i = 0; i < PREGS; i++) begin
      m_free[i] = (i >= LREGS); m_ab[0][i] = 0; m_ab[1][i] = 0; m_dep[i] = 0;
    end
    for (int s = 0; s < STORES; s++) begin m_sv[s] = 0; m_sdep[s] = 0; m_scan[s] = 0; end
    m_spec = 0; m_live = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state and plain renaming
    step("R1");
    ren("R1", 0, 5, 6, 1, 1, 0);          // first allocation is 8
    ren("R2", 0, 1, 3, 1, 4, 0);          // reads r1 -> 8
    ren("R6", 0, 4, 4, 0, 0, 1);          // pre-fork store
    fork_valid = 1; step("R11");
    ren("R3", 0, 1, 0, 1, 1, 0);          // r1 on path 0
    ren("R3", 1, 1, 0, 1, 1, 0);          // r1 on path 1, different register
    ren("R3", 0, 1, 1, 0, 0, 0);
    ren("R3", 1, 1, 1, 0, 0, 0);
    ren("R10", 0, 4, 4, 0, 0, 0);         // pre-fork mapping seen on both sides
    ren("R10", 1, 4, 4, 0, 0, 0);
    fork_valid = 1; step("R11");          // nested fork ignored
    ren("R6", 0, 1, 2, 0, 0, 1);          // winner-side store
    ren("R6", 1, 5, 5, 0, 0, 1);          // loser store on pre-branch data
    ren("R7", 1, 1, 0, 1, 6, 0);          // r6 derived from a loser result
    ren("R7", 1, 6, 6, 0, 0, 1);          // store on the chain
    wb("R6", 1);                          // still speculative: hold
    wb("R6", 0);                          // pre-fork store commits
    res_valid = 1; res_win = 0; in_valid = 1; in_has_dst = 1; in_dst = 2;
    step("R5");                           // rename refused in resolve cycle
    step("R5");
    ren("R5", 1, 1, 1, 1, 3, 0);          // loser path dropped
    ren("R8", 0, 1, 1, 1, 7, 0);          // winner map, freed register reused
    ren("R8", 1, 1, 1, 0, 0, 0);
    for (int s = 0; s < 4; s++) wb("R7", s);
    res_valid = 1; res_win = 1; step("R11"); // no speculation: ignored
    ren("R11", 0, 2, 2, 1, 2, 0);

    // second round, path 1 wins
    fork_valid = 1; step("R11");
    ren("R3", 0, 2, 2, 1, 5, 1);
    ren("R3", 1, 2, 2, 1, 5, 1);
    ren("R7", 0, 5, 0, 0, 0, 1);
    res_valid = 1; res_win = 1; step("R5");
    ren("R5", 0, 5, 5, 1, 3, 0);
    ren("R5", 1, 5, 5, 0, 0, 0);
    for (int s = 0; s < 4; s++) wb("R6", s);

    // exhaust the free list
    for (int k = 0; k < 30; k++) ren("R4", 1, 0, 0, 1, k % LREGS, 0);
    ren("R4", 1, 0, 0, 1, 3, 0);
    for (int r = 0; r < PREGS; r++)
      if (releasable(r)) begin
        rel_valid = 1; rel_preg = r[PW-1:0];
        break;
      end
    step("R9");
    ren("R9", 1, 0, 0, 1, 3, 0);

    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      int start;
      fork_valid = ($urandom % 8) == 0;
      res_valid = ($urandom % 10) == 0;
      res_win = $urandom % 2;
      in_valid = ($urandom % 4) != 0;
      in_path = $urandom % 2;
      in_src_a = $urandom % LREGS;
      in_src_b = $urandom % LREGS;
      in_has_dst = ($urandom % 4) != 0;
      in_dst = $urandom % LREGS;
      in_is_store = ($urandom % 4) == 0;
      wb_valid = ($urandom % 3) == 0;
      wb_sid = $urandom % STORES;
      if (low_free() < 0 || ($urandom % 4) == 0) begin
        start = $urandom % PREGS;
        for (int j = 0; j < PREGS; j++)
          if (releasable((start + j) % PREGS)) begin
            rel_valid = 1; rel_preg = PW'((start + j) % PREGS);
            break;
          end
      end
      step("R2");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule